// File: doc/BRIEF.md
# Extended Configuration Switch Executor

This block sits on the card side of a managed-flash command path. It holds a 512-byte extended configuration file and updates it when the controller hands it the 32-bit argument of the switch command (index 6). The block decodes an access mode, a target byte index, a value byte and a command-set field from that argument. It then does one of four things. It can OR the value into the target byte, clear the bits that the value marks, overwrite the byte, or load a new command-set selection.

An accepted command raises `busy` for a fixed number of cycles. This models the busy-signalled response that the switch command returns. An argument that arrives while `busy` is high is dropped. An argument with nonzero reserved bits, an out-of-range index, or a read-only target changes nothing and raises `sw_err`. A combinational byte read port lets the surrounding logic dump any of the 512 bytes.

The control is a two-state machine. `ST_IDLE` waits for `arg_valid`. A valid argument with no fault causes the transition *accept*, into `ST_BUSY`. A faulty argument causes the transition *refuse*, which keeps the machine in `ST_IDLE`. `ST_BUSY` counts down and takes the transition *release* back to `ST_IDLE` when the count reaches zero.

Top module: `xcfg_switch`

## Requirements
- R1: After reset every byte reads 0, except byte 192, which reads `REV_VAL` (default 0x06). Also after reset `cmd_set` is 3'b001, `busy` is 0 and `sw_err` is 0.
- R2: The argument fields are: bits [25:24] the access mode, bits [23:16] the target index, bits [15:8] the value, bits [2:0] the command set. Mode 3 writes the value into the target byte unchanged.
- R3: Mode 1 sets every target bit where the value byte has a 1 and leaves the other bits as they were.
- R4: Mode 2 clears every target bit where the value byte has a 1 and leaves the other bits as they were.
- R5: Mode 0 loads bits [2:0] into `cmd_set` (bit 0 normal, bit 1 secure, bit 2 content-protected secure). It changes no byte of the file, whatever the index and value fields hold.
- R6: A mode 1 to 3 argument that targets byte 160, or any byte from 192 through 503, leaves the file unchanged and sets `sw_err`.
- R7: An argument with any of bits [31:26] or [7:3] set leaves the file and `cmd_set` unchanged and sets `sw_err`.
- R8: An accepted argument sampled at clock edge t drives `busy` high after edge t. `busy` stays high for exactly `BUSY_CYCLES` cycles. A refused argument never raises `busy`.
- R9: An argument presented while `busy` is high is ignored: no byte changes, and `cmd_set`, `sw_err` and the busy timing are unaffected.
- R10: `sw_err` is updated by each argument taken in `ST_IDLE`. It goes to 1 when that argument is refused and to 0 when it is accepted, and it holds its value between such arguments.
- R11: `rd_data` returns the byte at `rd_addr` combinationally, for any address 0 to 511.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arg_valid | input | 1 | Switch argument strobe |
| arg | input | 32 | Switch command argument |
| rd_addr | input | 9 | Byte read address |
| rd_data | output | 8 | Byte at rd_addr |
| busy | output | 1 | Busy after an accepted switch |
| sw_err | output | 1 | Last argument was refused |
| cmd_set | output | 3 | Current command-set selection |

## Verification
The bench checks the edges of the read-only map: bytes 159, 161 and 191 must take writes, while 160, 192 and 255 must not. A design with off-by-one range limits would corrupt a protected byte or refuse a legal one. It sets reserved argument bits at both ends of the word. It issues a mode 0 argument that carries a live index and value, where a careless decoder would write the byte. It also sends a second argument during the busy window. A design that does not drop it would change a byte, clear `sw_err` or stretch the window.

// File: rtl/xcfg_pkg.sv
package xcfg_pkg;

    typedef enum logic [1:0] {
        ACC_CSET  = 2'd0,
        ACC_SET   = 2'd1,
        ACC_CLR   = 2'd2,
        ACC_WRITE = 2'd3
    } acc_mode_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } sw_state_e;

    typedef struct packed {
        acc_mode_e   mode;
        logic [7:0]  idx;
        logic [7:0]  val;
        logic [2:0]  cset;
        logic        rsvd_bad;
        logic        range_bad;
        logic        ro_hit;
    } sw_dec_t;

endpackage

// File: rtl/xcfg_decode.sv
module xcfg_decode
    import xcfg_pkg::*;
#(
    parameter int DEPTH     = 512,
    parameter int RO_SINGLE = 160,
    parameter int RO_LO     = 192,
    parameter int RO_HI     = 503
) (
    input  logic [31:0] arg,
    output sw_dec_t     dec
);
    localparam int IDX_EXT_W = $clog2(DEPTH) + 1;

    logic [IDX_EXT_W-1:0] idx_ext;

    always_comb begin
        dec.mode      = acc_mode_e'(arg[25:24]);
        dec.idx       = arg[23:16];
        dec.val       = arg[15:8];
        dec.cset      = arg[2:0];
        dec.rsvd_bad  = (|arg[31:26]) || (|arg[7:3]);
        idx_ext       = IDX_EXT_W'(arg[23:16]);
        dec.range_bad = (int'(idx_ext) >= DEPTH);
        dec.ro_hit    = (int'(idx_ext) == RO_SINGLE) ||
                        ((int'(idx_ext) >= RO_LO) && (int'(idx_ext) <= RO_HI));
    end
endmodule

// File: rtl/xcfg_regfile.sv
module xcfg_regfile #(
    parameter int         DEPTH     = 512,
    parameter int         REV_IDX   = 192,
    parameter logic [7:0] REV_VAL   = 8'h06,
    parameter int         RO_SINGLE = 160,
    parameter int         RO_LO     = 192,
    parameter int         RO_HI     = 503,
    localparam int        AW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] tgt_idx,
    output logic [7:0]    tgt_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= (i == REV_IDX) ? REV_VAL : 8'h00;
            end
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign tgt_data = mem_q[tgt_idx];
    assign rd_data  = mem_q[rd_addr];

    // R1: the revision byte never moves after reset
    p_rev_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_q[REV_IDX] == REV_VAL);

    // R6: no write strobe ever reaches a protected byte
    p_ro_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !((int'(wr_idx) == RO_SINGLE) ||
                    ((int'(wr_idx) >= RO_LO) && (int'(wr_idx) <= RO_HI))));
endmodule

// File: rtl/xcfg_ctrl.sv
module xcfg_ctrl
    import xcfg_pkg::*;
#(
    parameter int  DEPTH       = 512,
    parameter int  BUSY_CYCLES = 4,
    localparam int AW          = $clog2(DEPTH),
    localparam int CW          = $clog2(BUSY_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arg_valid,
    input  sw_dec_t       dec,
    input  logic [7:0]    tgt_old,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx,
    output logic [7:0]    wr_data,
    output logic          busy,
    output logic          sw_err,
    output logic [2:0]    cmd_set
);
    sw_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          err_q, err_d;
    logic [2:0]    cset_q, cset_d;
    logic          take, fault;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            err_q   <= 1'b0;
            cset_q  <= 3'b001;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            err_q   <= err_d;
            cset_q  <= cset_d;
        end
    end

    // next state and outputs
    always_comb begin
        take    = (state_q == ST_IDLE) && arg_valid;
        fault   = dec.rsvd_bad || dec.range_bad ||
                  ((dec.mode != ACC_CSET) && dec.ro_hit);
        state_d = state_q;
        cnt_d   = cnt_q;
        err_d   = err_q;
        cset_d  = cset_q;
        wr_en   = 1'b0;
        wr_idx  = AW'(dec.idx);
        unique case (dec.mode)
            ACC_SET:   wr_data = tgt_old | dec.val;
            ACC_CLR:   wr_data = tgt_old & ~dec.val;
            ACC_WRITE: wr_data = dec.val;
            default:   wr_data = tgt_old;
        endcase
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    err_d = fault;
                    if (!fault) begin
                        state_d = ST_BUSY;
                        cnt_d   = CW'(BUSY_CYCLES - 1);
                        if (dec.mode == ACC_CSET) cset_d = dec.cset;
                        else                      wr_en  = 1'b1;
                    end
                end
            end
            ST_BUSY: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy    = (state_q == ST_BUSY);
    assign sw_err  = err_q;
    assign cmd_set = cset_q;

    // R9: an argument during busy leaves flags alone
    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && arg_valid) |=> ($stable(sw_err) && $stable(cmd_set)));

    // R8: a refusal never opens a busy window
    p_refuse_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_err) |-> !busy);

    // R8: busy only begins after a strobe
    p_busy_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(arg_valid));

    // R5: command set only moves on an idle strobe
    p_cset_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_set) |-> ($past(arg_valid) && !$past(busy)));
endmodule

// File: rtl/xcfg_switch.sv
module xcfg_switch
    import xcfg_pkg::*;
#(
    parameter int         DEPTH       = 512,
    parameter int         BUSY_CYCLES = 4,
    parameter logic [7:0] REV_VAL     = 8'h06,
    localparam int        AW          = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arg_valid,
    input  logic [31:0]   arg,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          busy,
    output logic          sw_err,
    output logic [2:0]    cmd_set
);
    localparam int RO_SINGLE = 160;
    localparam int RO_LO     = 192;
    localparam int RO_HI     = 503;

    sw_dec_t       dec;
    logic          wr_en;
    logic [AW-1:0] wr_idx;
    logic [7:0]    wr_data, tgt_old;

    xcfg_decode #(
        .DEPTH(DEPTH), .RO_SINGLE(RO_SINGLE), .RO_LO(RO_LO), .RO_HI(RO_HI)
    ) u_decode (
        .arg (arg),
        .dec (dec)
    );

    xcfg_ctrl #(
        .DEPTH(DEPTH), .BUSY_CYCLES(BUSY_CYCLES)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .arg_valid(arg_valid),
        .dec      (dec),
        .tgt_old  (tgt_old),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .busy     (busy),
        .sw_err   (sw_err),
        .cmd_set  (cmd_set)
    );

    xcfg_regfile #(
        .DEPTH(DEPTH), .REV_IDX(RO_LO), .REV_VAL(REV_VAL),
        .RO_SINGLE(RO_SINGLE), .RO_LO(RO_LO), .RO_HI(RO_HI)
    ) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .tgt_idx (AW'(dec.idx)),
        .tgt_data(tgt_old),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: tb/xcfg_switch_tb.sv
module xcfg_switch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY       = 4;
    localparam int NV         = 14;

    // {arg, read index, expected byte, expected sw_err}
    localparam logic [31:0] V_ARG [NV] = '{
        32'h03B70200, 32'h01B70500, 32'h02B70300, 32'h03B3A500,
        32'h02B3FF00, 32'h03C05500, 32'h03A01100, 32'h039F2200,
        32'h03A13300, 32'h03BF4400, 32'h01FF0F00, 32'h83217700,
        32'h03217708, 32'h03210100 };
    localparam logic [8:0] V_IDX [NV] = '{
        9'd183, 9'd183, 9'd183, 9'd179, 9'd179, 9'd192, 9'd160,
        9'd159, 9'd161, 9'd191, 9'd255, 9'd33, 9'd33, 9'd33 };
    localparam logic [7:0] V_EXP [NV] = '{
        8'h02, 8'h07, 8'h04, 8'hA5, 8'h00, 8'h06, 8'h00,
        8'h22, 8'h33, 8'h44, 8'h00, 8'h00, 8'h00, 8'h01 };
    localparam logic V_ERR [NV] = '{
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1,
        1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0 };
    localparam string V_REQ [NV] = '{
        "R2", "R3", "R4", "R2", "R4", "R6", "R6",
        "R6", "R6", "R6", "R6", "R7", "R7", "R10" };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arg_valid = 1'b0;
    logic [31:0] arg = '0;
    logic [8:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        busy, sw_err;
    logic [2:0]  cmd_set;
    int          errors = 0;
    int          checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xcfg_switch #(.BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .arg_valid(arg_valid), .arg(arg),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .sw_err(sw_err), .cmd_set(cmd_set)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic peek(input logic [8:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // strobe for one cycle; returns at the negedge after the sampling edge
    task automatic issue(input logic [31:0] a);
        @(negedge clk);
        arg = a;
        arg_valid = 1'b1;
        @(negedge clk);
        arg_valid = 1'b0;
        arg = '0;
    endtask

    task automatic wait_idle();
        repeat (BUSY) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", "busy", 32'(busy), 0);
        check("R1", "sw_err", 32'(sw_err), 0);
        check("R1", "cmd_set", 32'(cmd_set), 1);
        peek(9'd192, d); check("R1", "byte192", 32'(d), 32'h06);
        peek(9'd183, d); check("R1", "byte183", 32'(d), 0);
        peek(9'd511, d); check("R11", "byte511", 32'(d), 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            issue(V_ARG[i]);
            check("R8", "busy after strobe", 32'(busy), 32'(!V_ERR[i]));
            check(V_REQ[i], "sw_err", 32'(sw_err), 32'(V_ERR[i]));
            wait_idle();
            peek(V_IDX[i], d);
            check(V_REQ[i], "byte", 32'(d), 32'(V_EXP[i]));
        end

        // R5: mode 0 with live index/value
        issue(32'h00B7FF06);
        check("R5", "cmd_set", 32'(cmd_set), 6);
        check("R5", "sw_err", 32'(sw_err), 0);
        wait_idle();
        peek(9'd183, d); check("R5", "byte183 untouched", 32'(d), 32'h04);

        // R7: reserved bit 26 blocks a command-set change
        issue(32'h04000003);
        check("R7", "cmd_set kept", 32'(cmd_set), 6);
        check("R7", "sw_err", 32'(sw_err), 1);

        // R8 window length and R9 ignore while busy
        issue(32'h03215A00);
        check("R10", "sw_err cleared", 32'(sw_err), 0);
        @(negedge clk);
        arg = 32'h03C0AA00;           // refused-type arg sent while busy
        arg_valid = 1'b1;
        @(negedge clk);
        arg = 32'h03210000;           // legal overwrite sent while busy
        @(negedge clk);
        arg_valid = 1'b0;
        arg = '0;
        check("R9", "sw_err held", 32'(sw_err), 0);
        check("R9", "busy last cycle", 32'(busy), 1);
        @(negedge clk);
        check("R8", "busy released", 32'(busy), 0);
        peek(9'd33, d); check("R9", "byte33 kept", 32'(d), 32'h5A);

        // R8: refused arg leaves busy low through the window
        issue(32'h03A00000);
        check("R8", "no busy on refusal", 32'(busy), 0);
        @(negedge clk);
        check("R10", "sw_err holds", 32'(sw_err), 1);

        // R11: upper half of file readable
        peek(9'd300, d); check("R11", "byte300", 32'(d), 0);

        finish_run();
    end
endmodule